// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block forms the data-memory address for a word-oriented signal processor with an 8-bit data address space. An instruction's low byte chooses between two addressing modes: a direct mode, which joins a one-bit page selector with a 7-bit offset carried in the instruction, and an indirect mode, which uses the low byte of one auxiliary register, the register being chosen by a pointer. The address is produced combinationally in the same cycle as the access strobe.

Indirect accesses may adjust the selected auxiliary register afterwards, by one up or one down, inside its low nine bits only. They may also reload the pointer from the instruction. The register file also takes loads from memory data, immediate loads from the instruction byte, and a test-and-decrement used by a loop branch. All register and pointer updates land on the clock edge that ends the access cycle.

Top module: `aux_addr_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) every auxiliary register reads 0 and the pointer reads 0.
- R2: With op_byte bit 7 at 0 (direct mode), mem_addr equals {page_bit, op_byte[6:0]}. A direct access changes neither the registers nor the pointer.
- R3: With op_byte bit 7 at 1 (indirect mode), mem_addr equals bits 7:0 of the auxiliary register that the pointer selects.
- R4: In an indirect access, op_byte bit 5 alone adds one and op_byte bit 4 alone subtracts one from bits 8:0 of the selected register, wrapping within those nine bits, with bits 15:9 kept. With both bits set or both clear the register is unchanged.
- R5: In an indirect access or load with op_byte bit 3 at 0, the pointer takes op_byte bit 0 at the clock edge. With bit 3 at 1, or in direct mode, the pointer is kept.
- R6: A status-store access (stat_en) in direct mode addresses page 1, that is 0x80 | op_byte[6:0], whatever page_bit holds. In indirect mode it post-modifies as in R4 but never changes the pointer.
- R7: A load (load_en) writes load_data into the register named by reg_sel. When reg_sel equals the pointer, the post-modify of R4 is suppressed so that the loaded value is what remains.
- R8: A load into the register that the pointer does not select also applies the R4 post-modify to the selected register in the same edge.
- R9: An immediate load (imm_en) writes op_byte, zero-extended to 16 bits, into the register named by reg_sel and leaves the pointer alone.
- R10: With banz_en, take_branch is 1 exactly when bits 8:0 of the selected register are nonzero. At the edge those nine bits are decremented by one, wrapping 0 to 0x1FF, with bits 15:9 kept. take_branch is 0 when banz_en is 0.
- R11: When several strobes are high together, only one operation takes effect, by priority banz_en, then imm_en, then load_en, then stat_en, then acc_en.
- R12: With no strobe high, the registers and the pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_byte | input | 8 | Low byte of the current instruction |
| page_bit | input | 1 | Data page selector for direct mode |
| acc_en | input | 1 | Plain memory access this cycle |
| stat_en | input | 1 | Status-store access this cycle |
| load_en | input | 1 | Load auxiliary register from memory data |
| imm_en | input | 1 | Load auxiliary register from op_byte |
| banz_en | input | 1 | Loop test and decrement of the selected register |
| reg_sel | input | 1 | Target register for load and immediate load |
| load_data | input | 16 | Memory data for load_en |
| mem_addr | output | 8 | Data-memory address for this cycle |
| aux_regs | output | 32 | Auxiliary registers, register i at bits 16*i+15:16*i |
| ptr_q | output | 1 | Current auxiliary register pointer |
| take_branch | output | 1 | Loop branch decision while banz_en is high |

## Verification
The hardest case to reach is the collision between a load and the post-modify of the same register. It needs the pointer already on the load target and an indirect opcode that asks for an increment. The stimulus first sets the pointer through an indirect access with bit 3 clear, then issues the load with bit 5 set, so the suppression of R7 becomes visible at the register port. The wrap cases need a register whose upper bits are nonzero and whose low nine bits sit at 0x1FF or 0. These are reached by loading such a value through the load path before the increments, the decrements and the loop test.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
// Package: shared field positions and operation kinds for the address generator.
package agu_pkg;
    localparam int ADDR_W   = 8;   // address width equals instruction low byte width
    localparam int IND_BIT  = 7;   // 1 selects indirect mode
    localparam int INC_BIT  = 5;   // post-increment request
    localparam int DEC_BIT  = 4;   // post-decrement request
    localparam int KEEP_BIT = 3;   // 1 keeps the pointer unchanged

    typedef enum logic [2:0] {
        OPK_IDLE,
        OPK_ACC,
        OPK_STAT,
        OPK_LOAD,
        OPK_IMM,
        OPK_BANZ
    } op_kind_e;
endpackage

// File: rtl/agu_op_sel.sv
`timescale 1ns/1ps
// Module: agu_op_sel
// Turns the operation strobes into a single operation kind by fixed priority.
// Assumes nothing about exclusivity; higher-priority strobes simply win.
module agu_op_sel
    import agu_pkg::*;
(
    input  logic     acc_en,
    input  logic     stat_en,
    input  logic     load_en,
    input  logic     imm_en,
    input  logic     banz_en,
    output op_kind_e kind
);
    // Priority encode: loop test, immediate, load, status store, access.
    always_comb begin
        if (banz_en)      kind = OPK_BANZ;
        else if (imm_en)  kind = OPK_IMM;
        else if (load_en) kind = OPK_LOAD;
        else if (stat_en) kind = OPK_STAT;
        else if (acc_en)  kind = OPK_ACC;
        else              kind = OPK_IDLE;
    end
endmodule

// File: rtl/agu_mod_field.sv
`timescale 1ns/1ps
// Module: agu_mod_field
// Adds or subtracts one in the low MOD_W bits of a DATA_W word and keeps the
// upper bits. Both or neither request leaves the word unchanged.
module agu_mod_field #(
    parameter int DATA_W = 16,
    parameter int MOD_W  = 9
) (
    input  logic [DATA_W-1:0] in_val,
    input  logic              inc,
    input  logic              dec,
    output logic [DATA_W-1:0] out_val
);
    localparam logic [MOD_W-1:0] ONE_M = MOD_W'(1);

    logic [MOD_W-1:0] low;

    // Step the low field, wrapping inside MOD_W bits.
    always_comb begin
        unique case ({inc, dec})
            2'b10:   low = in_val[MOD_W-1:0] + ONE_M;
            2'b01:   low = in_val[MOD_W-1:0] - ONE_M;
            default: low = in_val[MOD_W-1:0];
        endcase
    end

    assign out_val = {in_val[DATA_W-1:MOD_W], low};
endmodule

// File: rtl/agu_addr_mux.sv
`timescale 1ns/1ps
// Module: agu_addr_mux
// Chooses the data address: direct {page, offset} or the low byte of the
// selected auxiliary register. force_page pins the page to 1 (status store).
module agu_addr_mux
    import agu_pkg::*;
(
    input  logic [ADDR_W-1:0] op_byte,
    input  logic              page_bit,
    input  logic              force_page,
    input  logic [ADDR_W-1:0] sel_low,
    output logic [ADDR_W-1:0] mem_addr
);
    // Mode select on the indirect bit of the instruction byte.
    always_comb begin
        if (op_byte[IND_BIT])
            mem_addr = sel_low;
        else
            mem_addr = {page_bit | force_page, op_byte[ADDR_W-2:0]};
    end
endmodule

// File: rtl/agu_regfile.sv
`timescale 1ns/1ps
// Module: agu_regfile
// Holds the auxiliary registers and the pointer and applies post-modify,
// pointer reload, loads, immediate loads and the loop decrement at the edge.
// Assumes NUM_AR is a power of two so every pointer value names a register.
module agu_regfile
    import agu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MOD_W  = 9,
    parameter int NUM_AR = 2,
    parameter int PTR_W  = (NUM_AR > 1) ? $clog2(NUM_AR) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  op_kind_e                      kind,
    input  logic [ADDR_W-1:0]             op_byte,
    input  logic [PTR_W-1:0]              reg_sel,
    input  logic [DATA_W-1:0]             load_data,
    output logic [NUM_AR-1:0][DATA_W-1:0] ar_q,
    output logic [PTR_W-1:0]              ptr_q,
    output logic [DATA_W-1:0]             cur_val
);
    localparam logic [MOD_W-1:0] ONE_M = MOD_W'(1);

    logic [NUM_AR-1:0][DATA_W-1:0] ar_d;
    logic [PTR_W-1:0]              ptr_d;
    logic [DATA_W-1:0]             post_val;
    logic [DATA_W-1:0]             loop_val;
    logic                          is_mem;
    logic                          indirect;

    assign cur_val  = ar_q[ptr_q];
    assign indirect = op_byte[IND_BIT];
    assign is_mem   = (kind == OPK_ACC) || (kind == OPK_STAT) || (kind == OPK_LOAD);

    agu_mod_field #(.DATA_W(DATA_W), .MOD_W(MOD_W)) u_post (
        .in_val (cur_val),
        .inc    (op_byte[INC_BIT]),
        .dec    (op_byte[DEC_BIT]),
        .out_val(post_val)
    );

    agu_mod_field #(.DATA_W(DATA_W), .MOD_W(MOD_W)) u_loop (
        .in_val (cur_val),
        .inc    (1'b0),
        .dec    (1'b1),
        .out_val(loop_val)
    );

    // Next-state selection; a load is applied last so it overrides post-modify.
    always_comb begin
        ar_d  = ar_q;
        ptr_d = ptr_q;
        if (is_mem && indirect) begin
            ar_d[ptr_q] = post_val;
            if (!op_byte[KEEP_BIT] && (kind != OPK_STAT))
                ptr_d = op_byte[PTR_W-1:0];
        end
        if (kind == OPK_LOAD)
            ar_d[reg_sel] = load_data;
        if (kind == OPK_IMM)
            ar_d[reg_sel] = {{(DATA_W-ADDR_W){1'b0}}, op_byte};
        if (kind == OPK_BANZ)
            ar_d[ptr_q] = loop_val;
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar i = 0; i < NUM_AR; i++) begin : g_ar
        // One auxiliary register.
        always_ff @(posedge clk) begin
            if (!rst_n) ar_q[i] <= '0;
            else        ar_q[i] <= ar_d[i];
        end

        AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (((kind == OPK_ACC) || (kind == OPK_STAT)) && indirect && (ptr_q == i))
            |=> (ar_q[i][DATA_W-1:MOD_W] == $past(ar_q[i][DATA_W-1:MOD_W]))); // R4

        AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ((kind == OPK_LOAD) && (reg_sel == i))
            |=> (ar_q[i] == $past(load_data))); // R7

        AST_LOOP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
            ((kind == OPK_BANZ) && (ptr_q == i))
            |=> (ar_q[i][MOD_W-1:0] == ($past(ar_q[i][MOD_W-1:0]) - ONE_M))); // R10
    end

    AST_PTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (((kind == OPK_ACC) || (kind == OPK_LOAD)) && indirect && !op_byte[KEEP_BIT])
        |=> (ptr_q == $past(op_byte[PTR_W-1:0]))); // R5

    AST_PTR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((((kind == OPK_ACC) || (kind == OPK_LOAD)) && (!indirect || op_byte[KEEP_BIT]))
         || (kind == OPK_STAT))
        |=> $stable(ptr_q)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == OPK_IDLE) |=> ($stable(ar_q) && $stable(ptr_q))); // R12
endmodule

// File: rtl/aux_addr_gen.sv
`timescale 1ns/1ps
// Module: aux_addr_gen
// Data address generator with direct and indirect modes, post-modify of the
// low register field, pointer reload, register loads and a loop test.
// Assumes the address is consumed combinationally in the strobe cycle.
module aux_addr_gen
    import agu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MOD_W  = 9,
    parameter int NUM_AR = 2,
    localparam int PTR_W = (NUM_AR > 1) ? $clog2(NUM_AR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        op_byte,
    input  logic                     page_bit,
    input  logic                     acc_en,
    input  logic                     stat_en,
    input  logic                     load_en,
    input  logic                     imm_en,
    input  logic                     banz_en,
    input  logic [PTR_W-1:0]         reg_sel,
    input  logic [DATA_W-1:0]        load_data,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [NUM_AR*DATA_W-1:0] aux_regs,
    output logic [PTR_W-1:0]         ptr_q,
    output logic                     take_branch
);
    op_kind_e                      kind;
    logic [NUM_AR-1:0][DATA_W-1:0] ar_q;
    logic [DATA_W-1:0]             cur_val;

    agu_op_sel u_sel (
        .acc_en (acc_en),
        .stat_en(stat_en),
        .load_en(load_en),
        .imm_en (imm_en),
        .banz_en(banz_en),
        .kind   (kind)
    );

    agu_regfile #(.DATA_W(DATA_W), .MOD_W(MOD_W), .NUM_AR(NUM_AR), .PTR_W(PTR_W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .op_byte  (op_byte),
        .reg_sel  (reg_sel),
        .load_data(load_data),
        .ar_q     (ar_q),
        .ptr_q    (ptr_q),
        .cur_val  (cur_val)
    );

    agu_addr_mux u_mux (
        .op_byte   (op_byte),
        .page_bit  (page_bit),
        .force_page(kind == OPK_STAT),
        .sel_low   (cur_val[ADDR_W-1:0]),
        .mem_addr  (mem_addr)
    );

    assign aux_regs    = ar_q;
    assign take_branch = (kind == OPK_BANZ) && (cur_val[MOD_W-1:0] != '0);

    AST_STAT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == OPK_STAT) && !op_byte[IND_BIT]) |-> mem_addr[ADDR_W-1]); // R6

    AST_BRANCH_ONLY_ON_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        !banz_en |-> !take_branch); // R10
endmodule

// File: tb/aux_addr_gen_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module aux_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  op_byte;
    logic        page_bit, acc_en, stat_en, load_en, imm_en, banz_en, reg_sel;
    logic [15:0] load_data;
    logic [7:0]  mem_addr;
    logic [31:0] aux_regs;
    logic        ptr_q, take_branch;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    aux_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .op_byte(op_byte), .page_bit(page_bit),
        .acc_en(acc_en), .stat_en(stat_en), .load_en(load_en), .imm_en(imm_en),
        .banz_en(banz_en), .reg_sel(reg_sel), .load_data(load_data),
        .mem_addr(mem_addr), .aux_regs(aux_regs), .ptr_q(ptr_q),
        .take_branch(take_branch)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag, input logic [15:0] e0, input logic [15:0] e1,
                              input logic ep);
        check({tag, " ar0"}, {16'h0, aux_regs[15:0]}, {16'h0, e0});
        check({tag, " ar1"}, {16'h0, aux_regs[31:16]}, {16'h0, e1});
        check({tag, " ptr"}, {31'h0, ptr_q}, {31'h0, ep});
    endtask

    // Drive one operation; the comb outputs settle 1 ns later.
    task automatic drive(input logic a, input logic s, input logic l, input logic im,
                         input logic b, input logic [7:0] op, input logic pg,
                         input logic sel, input logic [15:0] d);
        acc_en = a; stat_en = s; load_en = l; imm_en = im; banz_en = b;
        op_byte = op; page_bit = pg; reg_sel = sel; load_data = d;
        #1;
    endtask

    // Close the cycle: pass the edge, then clear the strobes.
    task automatic commit();
        @(posedge clk);
        #1;
        acc_en = 0; stat_en = 0; load_en = 0; imm_en = 0; banz_en = 0;
        #1;
    endtask

    task automatic t_reset();
        check_regs("R1 reset", 16'h0000, 16'h0000, 1'b0);
    endtask

    task automatic t_immediate();
        drive(0, 0, 0, 1, 0, 8'hA5, 0, 0, 16'h0); commit();
        drive(0, 0, 0, 1, 0, 8'h3C, 0, 1, 16'h0); commit();
        check_regs("R9 immediate", 16'h00A5, 16'h003C, 1'b0);
    endtask

    task automatic t_direct();
        drive(1, 0, 0, 0, 0, 8'h15, 1, 0, 16'h0);
        check("R2 direct page1", {24'h0, mem_addr}, 32'h95);
        commit();
        drive(1, 0, 0, 0, 0, 8'h7F, 0, 0, 16'h0);
        check("R2 direct page0", {24'h0, mem_addr}, 32'h7F);
        commit();
        check_regs("R2 direct no change", 16'h00A5, 16'h003C, 1'b0);
    endtask

    task automatic t_post_modify();
        drive(0, 0, 1, 0, 0, 8'h00, 0, 0, 16'hABFF); commit();
        check_regs("R7 direct load", 16'hABFF, 16'h003C, 1'b0);
        drive(1, 0, 0, 0, 0, 8'hA8, 0, 0, 16'h0);
        check("R3 indirect addr ar0", {24'h0, mem_addr}, 32'hFF);
        commit();
        check_regs("R4 inc wrap keep upper", 16'hAA00, 16'h003C, 1'b0);
        drive(1, 0, 0, 0, 0, 8'h91, 0, 0, 16'h0);
        check("R3 indirect addr after inc", {24'h0, mem_addr}, 32'h00);
        commit();
        check_regs("R4 R5 dec wrap and reload", 16'hABFF, 16'h003C, 1'b1);
        drive(1, 0, 0, 0, 0, 8'hB0, 0, 0, 16'h0);
        check("R3 indirect addr ar1", {24'h0, mem_addr}, 32'h3C);
        commit();
        check_regs("R4 both bits no change R5 reload 0", 16'hABFF, 16'h003C, 1'b0);
    endtask

    task automatic t_status_store();
        drive(0, 1, 0, 0, 0, 8'h05, 0, 0, 16'h0);
        check("R6 status page forced", {24'h0, mem_addr}, 32'h85);
        commit();
        drive(0, 1, 0, 0, 0, 8'hA1, 0, 0, 16'h0);
        check("R6 status indirect addr", {24'h0, mem_addr}, 32'hFF);
        commit();
        check_regs("R6 status modify no ptr", 16'hAA00, 16'h003C, 1'b0);
    endtask

    task automatic t_load_collide();
        drive(0, 0, 1, 0, 0, 8'hA9, 0, 0, 16'h1234);
        check("R7 load addr", {24'h0, mem_addr}, 32'h00);
        commit();
        check_regs("R7 load beats increment", 16'h1234, 16'h003C, 1'b0);
        drive(0, 0, 1, 0, 0, 8'h91, 0, 1, 16'h5555);
        check("R8 load addr", {24'h0, mem_addr}, 32'h34);
        commit();
        check_regs("R8 load other plus dec", 16'h1233, 16'h5555, 1'b1);
    endtask

    task automatic t_loop();
        check("R10 no test no branch", {31'h0, take_branch}, 32'h0);
        drive(0, 0, 0, 0, 1, 8'h00, 0, 0, 16'h0);
        check("R10 nonzero branch", {31'h0, take_branch}, 32'h1);
        commit();
        check_regs("R10 dec", 16'h1233, 16'h5554, 1'b1);
        drive(0, 0, 1, 0, 0, 8'h00, 0, 1, 16'hFE00); commit();
        drive(0, 0, 0, 0, 1, 8'h00, 0, 0, 16'h0);
        check("R10 zero no branch", {31'h0, take_branch}, 32'h0);
        commit();
        check_regs("R10 wrap keep upper", 16'h1233, 16'hFFFF, 1'b1);
    endtask

    task automatic t_priority();
        drive(1, 0, 0, 1, 0, 8'hA0, 0, 0, 16'h0); commit();
        check_regs("R11 immediate beats access", 16'h00A0, 16'hFFFF, 1'b1);
    endtask

    task automatic t_idle();
        drive(0, 0, 0, 0, 0, 8'h91, 1, 0, 16'h7777);
        commit(); commit();
        check_regs("R12 idle hold", 16'h00A0, 16'hFFFF, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 8'h00, 0, 0, 16'h0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_immediate();
        t_direct();
        t_post_modify();
        t_status_store();
        t_load_collide();
        t_loop();
        t_priority();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule